// File: doc/BRIEF.md
# Edge-Flagged GPIO Port

An 8-bit general-purpose I/O port for a microcontroller subsystem. Software reaches it over a byte-wide register bus: write strobe, address and data in, read data out. Through that bus it programs, per pin:

- drive direction
- a pull-up request
- a peripheral-function select
- an edge polarity
- an interrupt enable

The block drives the output latch, the output enable, the pull-up request and the function select straight to the pad ring. It reports the pad levels back through the data register.

Every pad input passes through a two-stage synchroniser. A third flop keeps the previous synchronised sample, and edge detection compares that sample with the current one. When the selected edge appears on a pin, that pin's change flag is set. The flag stays set until software clears it by writing a one to it.

The level-type interrupt output is high while any flagged pin is also enabled. An enabled event also gives a one-cycle wake request that sleep control can use. Flags are not raised by whatever levels the pads happen to show while the synchroniser fills after reset.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset the direction register is 0xFF, so all pins are inputs and `pin_oe` is 0x00. The output latch, pull, function, polarity, enable and flag registers are 0x00, and `irq` and `wake` are low.
- R2: The register map is address 1 direction, 2 pull-up, 3 function select, 4 polarity and 5 interrupt enable. Each of these reads back the value last written. `pull_en` and `func_sel` show the pull-up and function-select registers. Address 7 reads 0x00.
- R3: A direction bit of 1 makes the pin an input and a 0 makes it an output. `pin_oe` bit n is high exactly when direction bit n is 0, from the cycle after the write.
- R4: A write to address 0 loads the output latch, which appears on `pin_out` from the cycle after the write. A read of address 0 returns the pad level after two synchroniser flops, never the latch. A pad change made before a clock edge is readable after the second edge.
- R5: Polarity bit 0 selects the rising edge and 1 selects the falling edge. The flag register is at address 6. The flag of a pin that sees its selected edge becomes readable after the third clock edge following the pad change. The opposite edge sets nothing.
- R6: Flags are sticky. Writing a 1 to a flag bit at address 6 clears it. Writing 0 bits leaves them unchanged, and later edges of the unselected polarity leave them unchanged.
- R7: If a clearing write and a new selected edge on the same pin land on the same clock edge, that pin's flag stays set. Other bits in the write are still cleared.
- R8: `irq` is high while any pin has both its flag and its enable set, and low otherwise. A flagged pin whose enable is 0 does not raise `irq`.
- R9: `wake` is high for one cycle, the cycle in which an enabled pin's flag is newly set. An event on a pin whose enable is 0 gives no wake.
- R10: Pad levels present during and right after reset set no flag while the synchroniser fills.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pad input levels, asynchronous |
| pin_out | output | 8 | Output latch to the pads |
| pin_oe | output | 8 | Output enable per pin, high means drive |
| pull_en | output | 8 | Pull-up request per pin |
| func_sel | output | 8 | 1 selects the peripheral function, 0 plain GPIO |
| irq | output | 1 | Level interrupt |
| wake | output | 1 | One-cycle wake request |

## Verification
Register writes take effect at the clock edge that samples the strobe, so readback, `pin_oe`, `pin_out`, `pull_en` and `func_sel` are checked in the cycle right after the write. A pad change shows on data reads after two edges. It shows in the flag register, on `irq` and on `wake` after three edges.

The bench changes pads and inputs only on falling edges. It then queues each expectation for the exact falling edge at which the result is due, including the edge just before it, where the old value must still hold. The clear-versus-edge case is built by timing the clearing write onto the same rising edge that sets the flag.

// File: rtl/gpio_edge_port.sv
module gpio_edge_port #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  output logic [W-1:0]  pin_out,
  output logic [W-1:0]  pin_oe,
  output logic [W-1:0]  pull_en,
  output logic [W-1:0]  func_sel,
  output logic          irq,
  output logic          wake
);
  localparam logic [AW-1:0] A_DATA = AW'(0);
  localparam logic [AW-1:0] A_DIR  = AW'(1);
  localparam logic [AW-1:0] A_PULL = AW'(2);
  localparam logic [AW-1:0] A_FUNC = AW'(3);
  localparam logic [AW-1:0] A_POL  = AW'(4);
  localparam logic [AW-1:0] A_IEN  = AW'(5);
  localparam logic [AW-1:0] A_STAT = AW'(6);

  logic [W-1:0] out_q, dir_q, pull_q, func_q, pol_q, ien_q, stat_q;
  logic [W-1:0] sync_a, sync_b, hist_q;
  logic [2:0]   arm_q;
  logic         wake_q;

  logic [W-1:0] rise, fall, evt, clr;

  assign rise = sync_b & ~hist_q;
  assign fall = ~sync_b & hist_q;
  assign evt  = arm_q[2] ? ((rise & ~pol_q) | (fall & pol_q)) : '0;
  assign clr  = (bus_wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      hist_q <= '0;
      arm_q  <= '0;
    end else begin
      sync_a <= pin_in;
      sync_b <= sync_a;
      hist_q <= sync_b;
      arm_q  <= {arm_q[1:0], 1'b1};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q  <= '0;
      dir_q  <= '1;
      pull_q <= '0;
      func_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA:  out_q  <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_PULL:  pull_q <= bus_wdata;
        A_FUNC:  func_q <= bus_wdata;
        A_POL:   pol_q  <= bus_wdata;
        A_IEN:   ien_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q <= '0;
      wake_q <= 1'b0;
    end else begin
      stat_q <= (stat_q & ~clr) | evt;
      wake_q <= |(evt & ien_q);
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = sync_b;
      A_DIR:   bus_rdata = dir_q;
      A_PULL:  bus_rdata = pull_q;
      A_FUNC:  bus_rdata = func_q;
      A_POL:   bus_rdata = pol_q;
      A_IEN:   bus_rdata = ien_q;
      A_STAT:  bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end

  assign pin_out  = out_q;
  assign pin_oe   = ~dir_q;
  assign pull_en  = pull_q;
  assign func_sel = func_q;
  assign irq      = |(stat_q & ien_q);
  assign wake     = wake_q;
endmodule

// File: rtl/gpio_edge_port_chk.sv
module gpio_edge_port_chk #(
  parameter int W  = 8,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pin_out,
  input logic [W-1:0]  pin_oe,
  input logic          irq,
  input logic          wake,
  input logic [W-1:0]  stat,
  input logic [W-1:0]  ien
);
  logic [W-1:0] clr_m;
  logic [1:0]   since_rst;

  assign clr_m = (bus_wr && bus_addr == AW'(6)) ? bus_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat & ~clr_m) & ~stat) == '0)); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ien) == '0) |-> !irq); // R8
  AST_WAKE_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ((stat & ien) != '0)); // R9
  AST_OE_FOLLOWS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(1)) |=> (pin_oe == ~$past(bus_wdata))); // R3
  AST_LATCH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == AW'(0)) |=> (pin_out == $past(bus_wdata))); // R4
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst != 2'd3) |-> (stat == '0)); // R10
endmodule

bind gpio_edge_port gpio_edge_port_chk #(.W(W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq(irq), .wake(wake), .stat(stat_q), .ien(ien_q)
);

// File: tb/gpio_edge_port_tb_top.sv
module gpio_edge_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in = 8'hA5;
  logic [7:0] pin_out, pin_oe, pull_en, func_sel;
  logic       irq, wake;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef enum int {K_RD, K_OE, K_PULL, K_FUNC, K_OUT, K_IRQ, K_WAKE} kind_t;
  typedef struct {
    kind_t      kind;
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  gpio_edge_port dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .pull_en(pull_en),
    .func_sel(func_sel), .irq(irq), .wake(wake)
  );

  function automatic logic [7:0] observe(kind_t k);
    case (k)
      K_RD:    return bus_rdata;
      K_OE:    return pin_oe;
      K_PULL:  return pull_en;
      K_FUNC:  return func_sel;
      K_OUT:   return pin_out;
      K_IRQ:   return {7'd0, irq};
      default: return {7'd0, wake};
    endcase
  endfunction

  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        act = observe(it.kind);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s kind=%s actual=%02h expected=%02h", it.tag, it.kind.name(), act, it.exp);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic exp_rd(logic [2:0] a, logic [7:0] e, string tag);
    item_t it;
    bus_addr = a;
    it.kind = K_RD; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic exp_sig(kind_t k, logic [7:0] e, string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick();
    // R1 reset state, R10 reset-time pads raise nothing
    exp_rd(3'd1, 8'hFF, "R1 dir");
    exp_sig(K_OE, 8'h00, "R1 oe");
    exp_sig(K_OUT, 8'h00, "R1 latch");
    exp_sig(K_IRQ, 8'h00, "R1 irq");
    exp_sig(K_WAKE, 8'h00, "R1 wake");
    tick();
    exp_rd(3'd2, 8'h00, "R1 pull"); tick();
    exp_rd(3'd3, 8'h00, "R1 func"); tick();
    exp_rd(3'd4, 8'h00, "R1 pol"); tick();
    exp_rd(3'd5, 8'h00, "R1 ien"); tick();
    exp_rd(3'd6, 8'h00, "R10 no flag from reset levels"); tick();
    exp_rd(3'd0, 8'hA5, "R4 pad read"); tick();

    // R2 / R3 register map and pad controls
    wr(3'd1, 8'h0F);
    exp_rd(3'd1, 8'h0F, "R2 dir readback");
    exp_sig(K_OE, 8'hF0, "R3 oe");
    tick();
    wr(3'd2, 8'h3C);
    exp_rd(3'd2, 8'h3C, "R2 pull readback");
    exp_sig(K_PULL, 8'h3C, "R2 pull_en");
    tick();
    wr(3'd3, 8'h81);
    exp_rd(3'd3, 8'h81, "R2 func readback");
    exp_sig(K_FUNC, 8'h81, "R2 func_sel");
    tick();
    exp_rd(3'd7, 8'h00, "R2 unused addr"); tick();

    // R4 latch versus pad read
    wr(3'd0, 8'h5A);
    exp_sig(K_OUT, 8'h5A, "R4 latch out");
    exp_rd(3'd0, 8'hA5, "R4 read is pad not latch");
    pin_in = 8'h00;
    tick();
    exp_rd(3'd0, 8'hA5, "R4 pad one edge"); tick();
    exp_rd(3'd0, 8'h00, "R4 pad two edges"); tick();

    // R5 rising edge, R8 irq, R9 wake
    wr(3'd5, 8'h01);
    pin_in = 8'h03;
    tick(2);
    exp_rd(3'd6, 8'h00, "R5 flag not before third edge");
    exp_sig(K_IRQ, 8'h00, "R8 irq early");
    exp_sig(K_WAKE, 8'h00, "R9 wake early");
    tick();
    exp_rd(3'd6, 8'h03, "R5 rising flags");
    exp_sig(K_IRQ, 8'h01, "R8 irq set");
    exp_sig(K_WAKE, 8'h01, "R9 wake pulse");
    tick();
    exp_rd(3'd6, 8'h03, "R6 sticky");
    exp_sig(K_IRQ, 8'h01, "R8 irq level");
    exp_sig(K_WAKE, 8'h00, "R9 wake one cycle");
    tick();

    wr(3'd6, 8'h01);
    exp_rd(3'd6, 8'h02, "R6 w1c");
    exp_sig(K_IRQ, 8'h00, "R8 disabled flag no irq");
    tick();
    wr(3'd6, 8'h00);
    exp_rd(3'd6, 8'h02, "R6 zero write no effect");
    tick();
    pin_in = 8'h01;
    tick(3);
    exp_rd(3'd6, 8'h02, "R6 opposite edge keeps flag"); tick();

    // R5 falling polarity
    wr(3'd4, 8'h04);
    pin_in = 8'h05;
    tick(3);
    exp_rd(3'd6, 8'h02, "R5 rising ignored on falling pin"); tick();
    pin_in = 8'h01;
    tick(2);
    exp_rd(3'd6, 8'h02, "R5 falling not yet"); tick();
    exp_rd(3'd6, 8'h06, "R5 falling flags");
    exp_sig(K_WAKE, 8'h00, "R9 no wake when disabled");
    tick();

    // R7 clear coinciding with a new edge on bit1
    pin_in = 8'h03;
    tick(2);
    wr(3'd6, 8'h06);
    exp_rd(3'd6, 8'h02, "R7 new edge wins over clear");
    tick();

    wr(3'd6, 8'hFF);
    exp_rd(3'd6, 8'h00, "R6 clear all");
    exp_sig(K_IRQ, 8'h00, "R8 irq low after clear");
    tick(2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule